// File: doc/BRIEF.md
# Low-latency DRAM command scheduler

This block sits on the controller side of a double-data-rate DRAM that has a small set of banks and does its own precharge. The DRAM has no activate or precharge command. Every access or refresh keeps its bank busy for a fixed row-cycle count. Row and column address travel with the command in the same cycle. The scheduler accepts read and write requests in arrival order on a valid/ready port. It puts out at most one command per clock on a registered command/address port and paces the per-bank refreshes the device needs. It also collects returned read bursts and tags each one with the identifier of the read that caused it.

Scheduling uses one busy timer per bank. The request at the head never passes another request; when its bank cannot take it, `req_ready` stays low. A refresh down-counter raises one refresh demand per interval and targets the banks in strict rotation. A pending refresh goes out as soon as its bank is free, ahead of any request. Two extra spacing rules protect the shared data bus. Data commands are kept a burst apart, and a write waits one turnaround cycle after the last read data.

Top module: `lowlat_dram_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_kind` is 0 (no command), `rsp_valid` is 0 and `req_ready` is 0 when `req_valid` is 0.
- R2: `cmd_kind` uses the codes 0 = none, 1 = read, 2 = write and 3 = refresh. A request accepted at a clock edge appears on the command port in the next cycle with the same bank, address, write data and mask. Read and refresh commands carry zero write data and a zero mask.
- R3: Two commands of any kind to the same bank are at least ROW_CYC cycles apart.
- R4: Requests issue strictly in arrival order. `req_ready` is never high for a request whose bank issued a command fewer than ROW_CYC cycles before the cycle the request would issue in.
- R5: With BURST_LEN of 4, the top address bit of every command is 0 whatever the request carried. With BURST_LEN of 2, the address passes through unchanged.
- R6: `req_wmask` is forwarded unchanged. Bit 0 masks the first half of the burst word (the low half) and bit 1 masks the second half (the high half); a set bit means that half is not written. A later read of the same bank and address returns the merged data.
- R7: The refresh interval is REF_RELOAD = CLK_MHZ*32000/65536 cycles. The k-th refresh (k from 1) goes to bank (k-1) mod NUM_BANKS and never issues before cycle k*REF_RELOAD+1, counted in clock edges after reset release.
- R8: A due refresh issues within ROW_CYC cycles of becoming due. No read or write to that bank issues while the refresh is pending, and requests to other banks keep issuing while its bank is still busy.
- R9: A write command issues no earlier than READ_LAT + BURST_LEN/2 + 1 cycles after the most recent read command.
- R10: Each read burst returns as BURST_LEN/2 cycles with `dev_dvld` high, and the first cycle lands in the low bits. After the last of these cycles, `rsp_valid` is high for one cycle with the whole burst on `rsp_data` and the `req_id` of that read. Responses come back in read issue order.
- R11: Any two read or write commands are at least BURST_LEN/2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request issues at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | $clog2(NUM_BANKS) | Target bank |
| req_addr | input | ADDR_W | Combined row/column address |
| req_wdata | input | BURST_LEN*DQ_W | Write burst word, first beat in the low bits |
| req_wmask | input | 2 | Half-burst write mask |
| req_id | input | ID_W | Tag returned with read data |
| cmd_kind | output | 2 | Command code |
| cmd_bank | output | $clog2(NUM_BANKS) | Command bank |
| cmd_addr | output | ADDR_W | Command address |
| cmd_wdata | output | BURST_LEN*DQ_W | Write burst word |
| cmd_wmask | output | 2 | Write mask |
| dev_dvld | input | 1 | Read data present this cycle |
| dev_rdata | input | 2*DQ_W | Two DDR beats of read data |
| rsp_valid | output | 1 | Completed read burst |
| rsp_id | output | ID_W | Tag of the completed read |
| rsp_data | output | BURST_LEN*DQ_W | Completed burst word |

## Verification
The bench builds the block with BURST_LEN 4, READ_LAT 6, ROW_CYC 7 and CLK_MHZ 200, which gives a refresh interval of 97 cycles. With a four-beat burst, the address bit forcing and the two-cycle spacing of data commands can both be observed. The long read latency opens a wide window in which the write turnaround can be seen. The 97-cycle interval is short enough that several dozen refreshes arrive during request traffic, so refreshes collide with busy banks and with waiting requests to the same bank.

// File: rtl/lds_pkg.sv
`timescale 1ns/1ps
package lds_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_REF   = 2'd3
    } cmd_e;
endpackage

// File: rtl/lds_bank_timers.sv
`timescale 1ns/1ps
module lds_bank_timers #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_CYC   = 5,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int TIM_W    = $clog2(ROW_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [BANK_W-1:0]    issue_bank,
    output logic [NUM_BANKS-1:0] busy
);
    typedef struct packed {
        logic [NUM_BANKS-1:0][TIM_W-1:0] tmr;
    } tim_t;

    tim_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (issue && issue_bank == BANK_W'(i))
                t_d.tmr[i] = TIM_W'(ROW_CYC - 1);
            else if (t_q.tmr[i] != '0)
                t_d.tmr[i] = t_q.tmr[i] - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_busy
        assign busy[b] = (t_q.tmr[b] != '0);
    end

    AST_BANK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !busy[issue_bank]); // R3
endmodule

// File: rtl/lds_ref_pacer.sv
`timescale 1ns/1ps
module lds_ref_pacer #(
    parameter int NUM_BANKS  = 8,
    parameter int REF_RELOAD = 97,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int CNT_W     = $clog2(REF_RELOAD + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_done,
    input  logic [BANK_W-1:0]    ref_done_bank,
    output logic [NUM_BANKS-1:0] pend
);
    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        logic [BANK_W-1:0]    ptr;
        logic [NUM_BANKS-1:0] pend;
    } pace_t;

    pace_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        if (ref_done) p_d.pend[ref_done_bank] = 1'b0;
        if (p_q.cnt == '0) begin
            p_d.cnt            = CNT_W'(REF_RELOAD - 1);
            p_d.pend[p_q.ptr]  = 1'b1;
            p_d.ptr            = (p_q.ptr == BANK_W'(NUM_BANKS - 1)) ? '0 : p_q.ptr + 1'b1;
        end else begin
            p_d.cnt = p_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q      <= '0;
            p_q.cnt  <= CNT_W'(REF_RELOAD - 1);
        end else begin
            p_q <= p_d;
        end
    end

    assign pend = p_q.pend;

    AST_REF_SINGLE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(p_q.pend)); // R7
    AST_REF_ONLY_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |-> p_q.pend[ref_done_bank]); // R8
endmodule

// File: rtl/lds_tag_fifo.sv
`timescale 1ns/1ps
module lds_tag_fifo #(
    parameter int DEPTH = 16,
    parameter int ID_W  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic [ID_W-1:0] head_id,
    output logic            full,
    output logic            empty
);
    typedef struct packed {
        logic [DEPTH-1:0][ID_W-1:0] mem;
        logic [PTR_W-1:0]           wp;
        logic [PTR_W-1:0]           rp;
        logic [CNT_W-1:0]           cnt;
    } fifo_t;

    fifo_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        if (push) begin
            f_d.mem[f_q.wp] = push_id;
            f_d.wp = (f_q.wp == PTR_W'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        end
        if (pop)
            f_d.rp = (f_q.rp == PTR_W'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        if (push && !pop)      f_d.cnt = f_q.cnt + 1'b1;
        else if (pop && !push) f_d.cnt = f_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head_id = f_q.mem[f_q.rp];
    assign full    = (f_q.cnt == CNT_W'(DEPTH));
    assign empty   = (f_q.cnt == '0);

    AST_TAG_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R10
    AST_TAG_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R10
endmodule

// File: rtl/lowlat_dram_sched.sv
`timescale 1ns/1ps
module lowlat_dram_sched
    import lds_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 19,
    parameter int DQ_W      = 16,
    parameter int ID_W      = 4,
    parameter int BURST_LEN = 4,
    parameter int READ_LAT  = 5,
    parameter int ROW_CYC   = 5,
    parameter int CLK_MHZ   = 200,
    parameter int TAG_DEPTH = 16,
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int BURST_CLKS = BURST_LEN / 2,
    localparam int WORD_W     = BURST_LEN * DQ_W,
    localparam int BEAT_W     = 2 * DQ_W,
    localparam int REF_RELOAD = (CLK_MHZ * 32000) / 65536,
    localparam int TURN_CNT   = READ_LAT + BURST_CLKS,
    localparam int GAP_W      = $clog2(TURN_CNT + 1),
    localparam int BUS_W      = $clog2(BURST_CLKS + 1),
    localparam int PH_W       = (BURST_CLKS > 1) ? $clog2(BURST_CLKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [1:0]        req_wmask,
    input  logic [ID_W-1:0]   req_id,
    output logic [1:0]        cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [WORD_W-1:0] cmd_wdata,
    output logic [1:0]        cmd_wmask,
    input  logic              dev_dvld,
    input  logic [BEAT_W-1:0] dev_rdata,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_id,
    output logic [WORD_W-1:0] rsp_data
);
    typedef struct packed {
        cmd_e              kind;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [1:0]        wmask;
        logic [GAP_W-1:0]  gap;
        logic [BUS_W-1:0]  bus;
        logic [PH_W-1:0]   phase;
        logic [WORD_W-1:0] rbuf;
        logic              rsp_v;
        logic [ID_W-1:0]   rsp_id;
        logic [WORD_W-1:0] rsp_data;
    } sched_t;

    sched_t s_q, s_d;

    logic [NUM_BANKS-1:0] bank_busy, ref_pend, ref_ready;
    logic                 ref_fire, head_ok, issue;
    logic [BANK_W-1:0]    ref_bank, issue_bank;
    logic                 tag_push, tag_pop, tag_full, tag_empty;
    logic [ID_W-1:0]      tag_head;
    logic [WORD_W-1:0]    merged;

    lds_bank_timers #(.NUM_BANKS(NUM_BANKS), .ROW_CYC(ROW_CYC)) u_timers (
        .clk(clk), .rst_n(rst_n), .issue(issue), .issue_bank(issue_bank), .busy(bank_busy));

    lds_ref_pacer #(.NUM_BANKS(NUM_BANKS), .REF_RELOAD(REF_RELOAD)) u_pacer (
        .clk(clk), .rst_n(rst_n), .ref_done(ref_fire), .ref_done_bank(ref_bank), .pend(ref_pend));

    lds_tag_fifo #(.DEPTH(TAG_DEPTH), .ID_W(ID_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .push(tag_push), .push_id(req_id), .pop(tag_pop),
        .head_id(tag_head), .full(tag_full), .empty(tag_empty));

    always_comb begin
        s_d       = s_q;
        s_d.kind  = CMD_NOP;
        s_d.rsp_v = 1'b0;
        if (s_q.gap != '0) s_d.gap = s_q.gap - 1'b1;
        if (s_q.bus != '0) s_d.bus = s_q.bus - 1'b1;

        // refresh due on a free bank wins the command slot
        ref_ready = ref_pend & ~bank_busy;
        ref_fire  = |ref_ready;
        ref_bank  = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--)
            if (ref_ready[i]) ref_bank = BANK_W'(i);

        head_ok = req_valid && !ref_fire && !bank_busy[req_bank] && !ref_pend[req_bank]
                  && (s_q.bus == '0)
                  && (req_write ? (s_q.gap == '0) : !tag_full);

        issue      = 1'b0;
        issue_bank = ref_bank;
        tag_push   = 1'b0;
        if (ref_fire) begin
            issue      = 1'b1;
            s_d.kind   = CMD_REF;
            s_d.bank   = ref_bank;
            s_d.addr   = '0;
            s_d.wdata  = '0;
            s_d.wmask  = '0;
        end else if (head_ok) begin
            issue      = 1'b1;
            issue_bank = req_bank;
            s_d.kind   = req_write ? CMD_WRITE : CMD_READ;
            s_d.bank   = req_bank;
            s_d.addr   = req_addr;
            if (BURST_LEN == 4) s_d.addr[ADDR_W-1] = 1'b0;
            s_d.wdata  = req_write ? req_wdata : '0;
            s_d.wmask  = req_write ? req_wmask : 2'b00;
            s_d.bus    = BUS_W'(BURST_CLKS - 1);
            if (!req_write) begin
                tag_push = 1'b1;
                s_d.gap  = GAP_W'(TURN_CNT);
            end
        end

        // read return assembly
        tag_pop = 1'b0;
        merged  = s_q.rbuf;
        merged[s_q.phase * BEAT_W +: BEAT_W] = dev_rdata;
        if (dev_dvld) begin
            if (s_q.phase == PH_W'(BURST_CLKS - 1)) begin
                s_d.phase    = '0;
                s_d.rsp_v    = 1'b1;
                s_d.rsp_data = merged;
                s_d.rsp_id   = tag_head;
                tag_pop      = 1'b1;
            end else begin
                s_d.phase = s_q.phase + 1'b1;
                s_d.rbuf  = merged;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready = head_ok;
    assign cmd_kind  = s_q.kind;
    assign cmd_bank  = s_q.bank;
    assign cmd_addr  = s_q.addr;
    assign cmd_wdata = s_q.wdata;
    assign cmd_wmask = s_q.wmask;
    assign rsp_valid = s_q.rsp_v;
    assign rsp_id    = s_q.rsp_id;
    assign rsp_data  = s_q.rsp_data;

    AST_ADDR_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.kind != CMD_NOP) |-> (BURST_LEN != 4 || !s_q.addr[ADDR_W-1])); // R5
    AST_REF_BEFORE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !ref_fire) |-> !ref_pend[issue_bank]); // R8
    AST_WRITE_NOT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.kind == CMD_WRITE) |-> ($past(s_q.kind) != CMD_READ)); // R9
    AST_RETURN_HAS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        dev_dvld |-> !tag_empty); // R10
endmodule

// File: tb/lowlat_dram_sched_test.sv
`timescale 1ns/1ps
module lowlat_dram_sched_test;
    localparam int NB  = 8;
    localparam int AW  = 19;
    localparam int DQ  = 16;
    localparam int IDW = 4;
    localparam int BL  = 4;
    localparam int RL  = 6;
    localparam int TRC = 7;
    localparam int MHZ = 200;
    localparam int BC  = BL / 2;
    localparam int WW  = BL * DQ;
    localparam int REL = (MHZ * 32000) / 65536;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, req_valid, req_ready, req_write, dev_dvld, rsp_valid;
    logic [2:0] req_bank, cmd_bank;
    logic [AW-1:0] req_addr, cmd_addr;
    logic [WW-1:0] req_wdata, cmd_wdata, rsp_data;
    logic [1:0] req_wmask, cmd_wmask, cmd_kind;
    logic [IDW-1:0] req_id, rsp_id;
    logic [2*DQ-1:0] dev_rdata;

    lowlat_dram_sched #(.NUM_BANKS(NB), .ADDR_W(AW), .DQ_W(DQ), .ID_W(IDW), .BURST_LEN(BL),
        .READ_LAT(RL), .ROW_CYC(TRC), .CLK_MHZ(MHZ), .TAG_DEPTH(16)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_wmask(req_wmask), .req_id(req_id), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_wmask(cmd_wmask), .dev_dvld(dev_dvld),
        .dev_rdata(dev_rdata), .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data));

    typedef struct {
        bit             wr;
        logic [2:0]     bank;
        logic [AW-1:0]  addr;
        logic [WW-1:0]  d;
        logic [1:0]     m;
        logic [IDW-1:0] id;
    } req_t;
    typedef struct {
        logic [IDW-1:0] id;
        logic [WW-1:0]  d;
    } rsp_t;

    req_t acc_q[$];
    rsp_t exp_q[$];
    logic [WW-1:0] mem [bit [AW+2:0]];
    logic slot_v [64];
    logic [2*DQ-1:0] slot_d [64];
    int last_bank [NB];
    int last_rd, last_data, ref_seen, cyc, nchk, nfail;
    logic [IDW-1:0] next_id;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] merge(input logic [WW-1:0] old, input logic [WW-1:0] d,
                                            input logic [1:0] m);
        logic [WW-1:0] r = old;
        if (!m[0]) r[WW/2-1:0]  = d[WW/2-1:0];
        if (!m[1]) r[WW-1:WW/2] = d[WW-1:WW/2];
        return r;
    endfunction

    function automatic logic [AW-1:0] fix_addr(input logic [AW-1:0] a);
        logic [AW-1:0] r = a;
        if (BL == 4) r[AW-1] = 1'b0;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // device model and command monitor
    always @(negedge clk) begin
        dev_dvld  = slot_v[cyc % 64];
        dev_rdata = slot_d[cyc % 64];
        slot_v[cyc % 64] = 1'b0;
        if (rst_n) begin
            if (cmd_kind == 2'd1 || cmd_kind == 2'd2) begin
                req_t h;
                int k;
                logic [WW-1:0] w;
                bit [AW+2:0] key;
                k = ref_seen + 1;
                if (acc_q.size() == 0) begin
                    chk(0, "R2", "command without request", 64'(cmd_kind), 64'd0);
                end else begin
                    h = acc_q.pop_front();
                    chk(cmd_kind == (h.wr ? 2'd2 : 2'd1) && cmd_bank == h.bank,
                        "R4", "order/kind", {cmd_kind, cmd_bank}, {(h.wr ? 2'd2 : 2'd1), h.bank});
                    chk(cmd_addr == fix_addr(h.addr), "R5", "address", 64'(cmd_addr), 64'(fix_addr(h.addr)));
                    chk(cmd_wdata == (h.wr ? h.d : '0) && cmd_wmask == (h.wr ? h.m : 2'b00),
                        "R2", "write payload", cmd_wdata, h.wr ? h.d : '0);
                    chk(cyc - last_bank[cmd_bank] >= TRC, "R3", "bank gap",
                        64'(cyc - last_bank[cmd_bank]), 64'(TRC));
                    chk(cyc - last_data >= BC, "R11", "data command gap", 64'(cyc - last_data), 64'(BC));
                    chk(!(cyc > k * REL && int'(cmd_bank) == (k - 1) % NB), "R8",
                        "access passed due refresh", 64'(cyc), 64'(k * REL));
                    key = {cmd_bank, cmd_addr};
                    if (cmd_kind == 2'd2) begin
                        chk(cyc - last_rd >= RL + BC + 1, "R9", "write turnaround",
                            64'(cyc - last_rd), 64'(RL + BC + 1));
                        mem[key] = merge(mem.exists(key) ? mem[key] : '0, cmd_wdata, cmd_wmask);
                    end else begin
                        w = mem.exists(key) ? mem[key] : '0;
                        exp_q.push_back('{id: h.id, d: w});
                        for (int j = 0; j < BC; j++) begin
                            slot_v[(cyc + RL + j) % 64] = 1'b1;
                            slot_d[(cyc + RL + j) % 64] = w[j*2*DQ +: 2*DQ];
                        end
                        last_rd = cyc;
                    end
                end
                last_bank[cmd_bank] = cyc;
                last_data = cyc;
            end else if (cmd_kind == 2'd3) begin
                int k;
                k = ref_seen + 1;
                chk(int'(cmd_bank) == (k - 1) % NB, "R7", "refresh bank", 64'(cmd_bank), 64'((k - 1) % NB));
                chk(cyc >= k * REL + 1, "R7", "refresh too early", 64'(cyc), 64'(k * REL + 1));
                chk(cyc <= k * REL + TRC, "R8", "refresh late", 64'(cyc), 64'(k * REL + TRC));
                chk(cyc - last_bank[cmd_bank] >= TRC, "R3", "refresh bank gap",
                    64'(cyc - last_bank[cmd_bank]), 64'(TRC));
                last_bank[cmd_bank] = cyc;
                ref_seen++;
            end
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R10", "unexpected response", 64'(rsp_id), 64'd0);
                end else begin
                    rsp_t e;
                    e = exp_q.pop_front();
                    chk(rsp_id == e.id, "R10", "response tag", 64'(rsp_id), 64'(e.id));
                    chk(rsp_data == e.d, "R6", "read-after-write data", rsp_data, e.d);
                end
            end
        end
    end

    task automatic send(input bit wr, input logic [2:0] b, input logic [AW-1:0] a,
                        input logic [WW-1:0] d, input logic [1:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bank = b; req_addr = a;
        req_wdata = d; req_wmask = m; req_id = next_id;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        chk((cyc + 1) - last_bank[b] >= TRC, "R4", "ready with busy bank",
            64'((cyc + 1) - last_bank[b]), 64'(TRC));
        acc_q.push_back('{wr: wr, bank: b, addr: a, d: d, m: m, id: next_id});
        next_id++;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R2 watchdog: done 0 expected 1");
        report();
    end

    initial begin
        logic [AW-1:0] a;
        logic [2:0] b;
        void'($urandom(32'd20240611));
        nchk = 0; nfail = 0; ref_seen = 0; next_id = '0;
        last_rd = -1000; last_data = -1000;
        for (int i = 0; i < NB; i++) last_bank[i] = -1000;
        for (int i = 0; i < 64; i++) begin slot_v[i] = 1'b0; slot_d[i] = '0; end
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_bank = '0; req_addr = '0;
        req_wdata = '0; req_wmask = '0; req_id = '0; dev_dvld = 1'b0; dev_rdata = '0;
        repeat (4) @(negedge clk);
        chk(cmd_kind == 2'd0 && !rsp_valid && !req_ready, "R1", "reset outputs",
            {cmd_kind, rsp_valid, req_ready}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_kind == 2'd0 && !rsp_valid, "R1", "first cycle after reset",
            {cmd_kind, rsp_valid}, 64'd0);

        // directed: full write and readback, halves masked in turn, top bit alias
        send(1, 3'd3, 19'h00001, 64'h1111_2222_3333_4444, 2'b00);
        send(0, 3'd3, 19'h00001, '0, 2'b00);
        send(1, 3'd3, 19'h00001, 64'hAAAA_BBBB_CCCC_DDDD, 2'b01); // R6 low half kept
        send(0, 3'd3, 19'h00001, '0, 2'b00);
        send(1, 3'd3, 19'h00001, 64'h5555_6666_7777_8888, 2'b10); // R6 high half kept
        send(0, 3'd3, 19'h00001, '0, 2'b00);
        send(1, 3'd5, 19'h40002, 64'hDEAD_BEEF_0BAD_F00D, 2'b00); // R5 alias write
        send(0, 3'd5, 19'h00002, '0, 2'b00);
        // R9: read then immediate write to another bank
        send(0, 3'd1, 19'h00000, '0, 2'b00);
        send(1, 3'd2, 19'h00003, 64'h0123_4567_89AB_CDEF, 2'b00);
        // R3: same bank back to back
        send(1, 3'd6, 19'h00001, 64'hFEED_FACE_CAFE_BABE, 2'b00);
        send(1, 3'd6, 19'h00002, 64'h0F0F_0F0F_F0F0_F0F0, 2'b00);

        b = 3'd0;
        for (int n = 0; n < 500; n++) begin
            if ($urandom % 10 >= 3) b = 3'($urandom % NB);
            a = '0;
            a[1:0]  = 2'($urandom % 4);
            a[AW-1] = 1'($urandom % 2);
            send(1'($urandom % 2), b, a, {$urandom, $urandom}, 2'($urandom % 4));
            if ($urandom % 4 == 0) repeat ($urandom % 5) @(negedge clk);
        end

        for (int w = 0; w < 400 && (exp_q.size() != 0 || acc_q.size() != 0); w++)
            @(negedge clk);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0 && acc_q.size() == 0, "R10", "outstanding at end",
            64'(exp_q.size() + acc_q.size()), 64'd0);
        chk(ref_seen >= (cyc - TRC) / REL && ref_seen <= cyc / REL, "R7", "refresh count",
            64'(ref_seen), 64'(cyc / REL));
        report();
    end
endmodule